// File: doc/BRIEF.md
# Message Buffer Interrupt Aggregator

This block collects completion pulses from 64 message buffers, plus bus-off and error condition pulses, and turns them into 20 interrupt request lines. Each buffer owns one sticky flag bit. A flag stays set until the CPU writes a 1 to that bit. A separate mask bit decides whether the flag reaches an interrupt line. A transmit completion and a receive completion set the same flag, so the flag carries no direction.

Buffers 0 to 15 each drive their own line. Buffers 16 to 31 share one OR-combined line, and buffers 32 to 63 share a second one. The bus-off and error conditions follow the same scheme. Their sticky status bits sit in a status word and their enable bits sit in a control word. When a grouped line fires, the CPU reads the flag words to find which buffer raised it.

The CPU reaches the block through a simple port with one select, a write strobe, write data and combinational read data. The select codes are:

| Code | Word | Contents |
|---|---|---|
| 0 | flags, low | buffers 0–31, bit n = buffer n |
| 1 | flags, high | buffers 32–63, bit n = buffer 32+n |
| 2 | masks, low | buffers 0–31 |
| 3 | masks, high | buffers 32–63 |
| 4 | control | bit 0 = bus-off enable, bit 1 = error enable |
| 5 | status | bit 0 = bus-off, bit 1 = error |

Top module: `mbirq_agg`

## Requirements
- R1: After reset, all flag, mask, control and status bits are 0 and all 20 interrupt lines are low.
- R2: A pulse on done_evt[n] sets flag n at the next clock edge. Flag n reads back at select 0 bit n for n < 32, and at select 1 bit n-32 otherwise.
- R3: Writing select 0 or 1 clears each flag whose write-data bit is 1. A write-data bit of 0 leaves its flag unchanged.
- R4: When a set event and a write-1 clear hit the same flag or status bit in the same cycle, the bit ends up set. Other bits cleared by that write still clear.
- R5: For n in 0..15, irq_buf[n] is high exactly when flag n and mask n are both 1.
- R6: irq_grp_mid is the OR of flag AND mask over buffers 16–31.
- R7: irq_grp_hi is the OR of flag AND mask over buffers 32–63.
- R8: Bus-off and error pulses set status bit 0 and bit 1. These bits clear on write-1 at select 5. irq_busoff equals status bit 0 AND control bit 0, and irq_err equals status bit 1 AND control bit 1.
- R9: The mask words (select 2, 3) and control bits 1:0 (select 4) are plainly written and read back.
- R10: Select codes 6 and 7 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_evt | input | 64 | Per-buffer completion pulses |
| busoff_evt | input | 1 | Bus-off condition pulse |
| err_evt | input | 1 | Error condition pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_buf | output | 16 | Dedicated lines for buffers 0–15 |
| irq_busoff | output | 1 | Bus-off interrupt |
| irq_err | output | 1 | Error interrupt |
| irq_grp_mid | output | 1 | OR line for buffers 16–31 |
| irq_grp_hi | output | 1 | OR line for buffers 32–63 |

## Verification
The assertions check on every cycle that:
- a completion pulse lands in its flag;
- a write-1 leaves no unprotected flag set;
- flags and masks stay put when nothing touches them;
- a masked-off dedicated line never fires;
- a masked completion raises its grouped line or bus-off line one edge later.

Only the bench's scenarios can show the following:
- the exact read-back layout of the flag, mask, control and status words;
- the set-over-clear priority when both land on the same bit;
- that writing 0 spares a flag;
- that the unused select codes are inert;
- that a reset in mid-run returns every word to zero.

// File: rtl/mbirq_agg.sv
module mbirq_agg #(
  parameter int DW      = 32,
  parameter int NDIRECT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*DW-1:0]   done_evt,
  input  logic              busoff_evt,
  input  logic              err_evt,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [NDIRECT-1:0] irq_buf,
  output logic              irq_busoff,
  output logic              irq_err,
  output logic              irq_grp_mid,
  output logic              irq_grp_hi
);
  localparam int NBUF = 2 * DW;

  localparam logic [2:0] SEL_FLO  = 3'd0;
  localparam logic [2:0] SEL_FHI  = 3'd1;
  localparam logic [2:0] SEL_MLO  = 3'd2;
  localparam logic [2:0] SEL_MHI  = 3'd3;
  localparam logic [2:0] SEL_CTRL = 3'd4;
  localparam logic [2:0] SEL_STAT = 3'd5;

  logic [NBUF-1:0] flag_q, mask_q, masked;
  logic [1:0]      ctrl_q, stat_q;
  logic [NBUF-1:0] flag_clr;
  logic [1:0]      stat_clr;

  assign flag_clr[DW-1:0]    = (reg_wr && reg_sel == SEL_FLO) ? reg_wdata : '0;
  assign flag_clr[NBUF-1:DW] = (reg_wr && reg_sel == SEL_FHI) ? reg_wdata : '0;
  assign stat_clr            = (reg_wr && reg_sel == SEL_STAT) ? reg_wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      flag_q <= (flag_q & ~flag_clr) | done_evt;
      stat_q <= (stat_q & ~stat_clr) | {err_evt, busoff_evt};
      if (reg_wr && reg_sel == SEL_MLO)  mask_q[DW-1:0]    <= reg_wdata;
      if (reg_wr && reg_sel == SEL_MHI)  mask_q[NBUF-1:DW] <= reg_wdata;
      if (reg_wr && reg_sel == SEL_CTRL) ctrl_q            <= reg_wdata[1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_FLO:  reg_rdata = flag_q[DW-1:0];
      SEL_FHI:  reg_rdata = flag_q[NBUF-1:DW];
      SEL_MLO:  reg_rdata = mask_q[DW-1:0];
      SEL_MHI:  reg_rdata = mask_q[NBUF-1:DW];
      SEL_CTRL: reg_rdata[1:0] = ctrl_q;
      SEL_STAT: reg_rdata[1:0] = stat_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign masked      = flag_q & mask_q;
  assign irq_buf     = masked[NDIRECT-1:0];
  assign irq_grp_mid = |masked[DW-1:NDIRECT];
  assign irq_grp_hi  = |masked[NBUF-1:DW];
  assign irq_busoff  = stat_q[0] & ctrl_q[0];
  assign irq_err     = stat_q[1] & ctrl_q[1];
endmodule

// File: rtl/mbirq_agg_chk.sv
module mbirq_agg_chk #(
  parameter int DW      = 32,
  parameter int NDIRECT = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*DW-1:0]    done_evt,
  input logic               busoff_evt,
  input logic               reg_wr,
  input logic [2:0]         reg_sel,
  input logic [DW-1:0]      reg_wdata,
  input logic [NDIRECT-1:0] irq_buf,
  input logic               irq_busoff,
  input logic               irq_grp_mid,
  input logic               irq_grp_hi,
  input logic [2*DW-1:0]    flag_q,
  input logic [2*DW-1:0]    mask_q,
  input logic [1:0]         ctrl_q
);
  a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_evt) |=> ((flag_q & $past(done_evt)) == $past(done_evt)));

  // R3 and R4: every bit written with 1 and not hit by a set event is clear.
  a_r3_w1c_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'd0) |=>
      ((flag_q[DW-1:0] & $past(reg_wdata & ~done_evt[DW-1:0])) == '0));

  a_r3_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && done_evt == '0) |=> $stable(flag_q));

  a_r5_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_buf & ~mask_q[NDIRECT-1:0]) == '0));

  a_r6_grp_mid: assert property (@(posedge clk) disable iff (!rst_n)
    (((done_evt[DW-1:NDIRECT] & mask_q[DW-1:NDIRECT]) != '0) && !reg_wr) |=> irq_grp_mid);

  a_r7_grp_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (((done_evt[2*DW-1:DW] & mask_q[2*DW-1:DW]) != '0) && !reg_wr) |=> irq_grp_hi);

  a_r8_busoff: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff_evt && ctrl_q[0] && !reg_wr) |=> irq_busoff);

  a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr) |=> $stable(mask_q));
endmodule

bind mbirq_agg mbirq_agg_chk #(.DW(DW), .NDIRECT(NDIRECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .busoff_evt(busoff_evt),
  .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .irq_buf(irq_buf), .irq_busoff(irq_busoff), .irq_grp_mid(irq_grp_mid),
  .irq_grp_hi(irq_grp_hi), .flag_q(flag_q), .mask_q(mask_q), .ctrl_q(ctrl_q)
);

// File: tb/mbirq_agg_bench.sv
module mbirq_agg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] done_evt = '0;
  logic        busoff_evt = 1'b0, err_evt = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq_buf;
  logic        irq_busoff, irq_err, irq_grp_mid, irq_grp_hi;
  logic [19:0] irq_vec;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mbirq_agg u_mbirq_agg (
    .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .busoff_evt(busoff_evt),
    .err_evt(err_evt), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_buf(irq_buf), .irq_busoff(irq_busoff),
    .irq_err(irq_err), .irq_grp_mid(irq_grp_mid), .irq_grp_hi(irq_grp_hi)
  );

  // irq_vec: [15:0] dedicated, 16 bus-off, 17 error, 18 mid group, 19 high group
  assign irq_vec = {irq_grp_hi, irq_grp_mid, irq_err, irq_busoff, irq_buf};

  localparam logic [2:0] WR = 3'd0, RD = 3'd1, EVLO = 3'd2, EVHI = 3'd3, EVSP = 3'd4, IRQ = 3'd5;
  localparam int NV = 38;
  // {op, sel, wdata, expected, requirement}
  localparam logic [73:0] VEC [NV] = '{
    {RD,   3'd0, 32'h0,        32'h0,        4'd1},   // R1
    {IRQ,  3'd0, 32'h0,        32'h0,        4'd1},   // R1
    {EVLO, 3'd0, 32'h00010005, 32'h0,        4'd2},
    {RD,   3'd0, 32'h0,        32'h00010005, 4'd2},   // R2
    {IRQ,  3'd0, 32'h0,        32'h0,        4'd5},   // R5 all masked off
    {WR,   3'd2, 32'h4,        32'h0,        4'd9},
    {RD,   3'd2, 32'h0,        32'h4,        4'd9},   // R9
    {IRQ,  3'd0, 32'h0,        32'h4,        4'd5},   // R5
    {WR,   3'd2, 32'h00010004, 32'h0,        4'd6},
    {IRQ,  3'd0, 32'h0,        32'h00040004, 4'd6},   // R6
    {WR,   3'd0, 32'h4,        32'h0,        4'd3},
    {RD,   3'd0, 32'h0,        32'h00010001, 4'd3},   // R3
    {IRQ,  3'd0, 32'h0,        32'h00040000, 4'd5},
    {WR,   3'd0, 32'h0,        32'h0,        4'd3},
    {RD,   3'd0, 32'h0,        32'h00010001, 4'd3},   // R3 zero spares
    {EVHI, 3'd0, 32'h80000000, 32'h0,        4'd2},
    {RD,   3'd1, 32'h0,        32'h80000000, 4'd2},   // R2 high word
    {IRQ,  3'd0, 32'h0,        32'h00040000, 4'd7},   // R7 masked
    {WR,   3'd3, 32'h80000000, 32'h0,        4'd7},
    {IRQ,  3'd0, 32'h0,        32'h000C0000, 4'd7},   // R7
    {WR,   3'd1, 32'hFFFFFFFF, 32'h0,        4'd3},
    {RD,   3'd1, 32'h0,        32'h0,        4'd3},   // R3 high word
    {IRQ,  3'd0, 32'h0,        32'h00040000, 4'd7},
    {EVSP, 3'd0, 32'h1,        32'h0,        4'd8},
    {RD,   3'd5, 32'h0,        32'h1,        4'd8},   // R8
    {IRQ,  3'd0, 32'h0,        32'h00040000, 4'd8},
    {WR,   3'd4, 32'h3,        32'h0,        4'd9},
    {RD,   3'd4, 32'h0,        32'h3,        4'd9},   // R9
    {IRQ,  3'd0, 32'h0,        32'h00050000, 4'd8},
    {EVSP, 3'd0, 32'h2,        32'h0,        4'd8},
    {IRQ,  3'd0, 32'h0,        32'h00070000, 4'd8},
    {WR,   3'd5, 32'h1,        32'h0,        4'd8},
    {RD,   3'd5, 32'h0,        32'h2,        4'd8},
    {IRQ,  3'd0, 32'h0,        32'h00060000, 4'd8},
    {WR,   3'd6, 32'hFFFF,     32'h0,        4'd10},
    {RD,   3'd6, 32'h0,        32'h0,        4'd10},  // R10
    {RD,   3'd0, 32'h0,        32'h00010001, 4'd10},  // R10 no side effect
    {RD,   3'd3, 32'h0,        32'h80000000, 4'd9}
  };

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input int req, input logic [2:0] s, input logic [31:0] exp);
    @(negedge clk); reg_sel = s; #1 check(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op; logic [2:0] s; logic [31:0] d, e; int req;
      {op, s, d, e} = VEC[i][73:4];
      req = int'(VEC[i][3:0]);
      case (op)
        WR:   wr(s, d);
        RD:   rd(req, s, e);
        EVLO: begin @(negedge clk); done_evt[31:0] = d; @(negedge clk); done_evt = '0; end
        EVHI: begin @(negedge clk); done_evt[63:32] = d; @(negedge clk); done_evt = '0; end
        EVSP: begin @(negedge clk); {err_evt, busoff_evt} = d[1:0];
                    @(negedge clk); {err_evt, busoff_evt} = 2'b00; end
        default: begin @(negedge clk); #1 check(req, {12'h0, irq_vec}, e); end
      endcase
    end

    // R4: set and write-1 clear on the same flag bit; bit 0 still clears
    @(negedge clk); done_evt = 64'h20; reg_wr = 1'b1; reg_sel = 3'd0; reg_wdata = 32'h21;
    @(negedge clk); done_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(4, 3'd0, 32'h00010020);                                           // R4
    // R4 on status: bus-off set wins, error bit clears
    @(negedge clk); busoff_evt = 1'b1; reg_wr = 1'b1; reg_sel = 3'd5; reg_wdata = 32'h3;
    @(negedge clk); busoff_evt = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd(4, 3'd5, 32'h1);                                                  // R4

    // R1: reset in mid-run clears every word and line
    @(negedge clk); rst_n = 1'b0;
    for (int k = 0; k < 6; k++) rd(1, 3'(k), 32'h0);                     // R1
    #1 check(1, {12'h0, irq_vec}, 32'h0);                                // R1
    @(negedge clk); rst_n = 1'b1;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule